// File: doc/BRIEF.md
# Clock-Switch Mute Sequencer

This block sequences the hand-over between a free-running crystal-derived clock and a recovered PLL clock inside a digital audio receiver. Each time the PLL gains or loses lock, the output clocks change source. Around every such change the block drives a mute pulse so that downstream audio logic can discard samples. It also keeps an error flag that stays set until a lock is confirmed, and a clock-source select that steers an external glitch-free clock multiplexer.

All inputs are synchronous enables in one system clock domain: a PLL lock flag, an input-data-detected flag and a one-cycle word-clock tick from the crystal side. The lock-in sequence waits for a crystal tick, asserts mute, moves the source select to the PLL after a programmable number of ticks, then releases mute and the error flag together after a longer wait. The unlock sequence reacts at once: it raises the error flag, asserts mute and returns to the crystal clock in the same cycle. It then holds mute for a tick count or for a fixed number of system cycles, as configured.

Top module: `clk_switch_mute`

## Requirements
- R1: After reset, clkSrcSel is 0 (crystal), errFlag is 1 and mute is inactive (muteOut equals the inverse of cfgMutePol).
- R2: Mute polarity: with cfgMutePol = 0 muteOut is 0 while mute is active and 1 otherwise; with cfgMutePol = 1 it is 1 while active and 0 otherwise.
- R3: While idle, mute becomes active in the cycle after a cycle with pllLocked, dataDetected and xtalTick all high. Without xtalTick, or with dataDetected low, mute stays inactive.
- R4: cfgSwitchDelay code c selects SW_BASE << c crystal ticks (default 128, 256, 512, 1024). clkSrcSel goes to 1 (PLL) in the cycle after the cycle that carries the (SW_BASE << c)-th tick counted after the tick that asserted mute.
- R5: On lock-in, mute and errFlag are released on the same edge: the edge after the edge that counts the LOCK_WAIT_TICKS-th tick following the asserting tick.
- R6: When pllLocked is low in the locked state, errFlag is 1, mute is active and clkSrcSel is 0 in the next cycle.
- R7: With cfgUnlockMode = 0, unlock mute is released on the edge after the edge that counts the UNLOCK_TICKS-th crystal tick following the unlock edge.
- R8: With cfgUnlockMode = 1, unlock mute stays active for FIXED_CYCLES + 1 system clock cycles after the unlock edge, independent of xtalTick.
- R9: If pllLocked drops during a lock-in sequence, that sequence is aborted. In the next cycle clkSrcSel is 0, errFlag is 1 and mute stays active, and the unlock count starts.
- R10: clkSrcSel changes value only in a cycle in which mute is active.
- R11: After the unlock mute ends, the block is idle with errFlag 1, mute inactive and clkSrcSel 0, and pllLocked returning during the unlock count does not shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pllLocked | input | 1 | PLL lock status |
| dataDetected | input | 1 | Valid input data present |
| xtalTick | input | 1 | One-cycle crystal word-clock tick |
| cfgMutePol | input | 1 | Mute polarity (0 = active low) |
| cfgSwitchDelay | input | 2 | Lock-in switch delay code |
| cfgUnlockMode | input | 1 | Unlock mute length: 0 = tick count, 1 = fixed cycles |
| muteOut | output | 1 | Mute pulse, polarity per cfgMutePol |
| errFlag | output | 1 | Lock error flag, 1 until lock is confirmed |
| clkSrcSel | output | 1 | Clock source select: 0 = crystal, 1 = PLL |

## Verification
The bench builds the block with SW_BASE = 2, LOCK_WAIT_TICKS = 20, UNLOCK_TICKS = 6 and FIXED_CYCLES = 10. This shrinks the delays from thousands of ticks to a handful, so every switch-delay code, both unlock modes and both polarities can be walked tick by tick, with the exact switching tick checked. With these settings the abort of a lock-in sequence after the source has already moved to the PLL can also be reached in a few dozen cycles.

// File: rtl/csm_pkg.sv
package csm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_LOCKING   = 2'd1,
    ST_LOCKED    = 2'd2,
    ST_UNLOCKING = 2'd3
  } seqState_t;

  // strobes from the control to the counter datapath
  typedef struct packed {
    logic clear;
    logic inc;
  } cntStrobe_t;

endpackage

// File: rtl/csm_count.sv
module csm_count import csm_pkg::*; #(
  parameter int SW_BASE         = 128,
  parameter int LOCK_WAIT_TICKS = 1536,
  parameter int UNLOCK_TICKS    = 16384,
  parameter int FIXED_CYCLES    = 132710
) (
  input  logic       clk,
  input  logic       rstN,
  input  cntStrobe_t strobe,
  input  logic [1:0] swCode,
  input  logic       unlockMode,
  output logic       hitSwitch,
  output logic       hitWait,
  output logic       hitUnlock
);

  localparam int SW_MAX = SW_BASE * 8;
  localparam int MAX_A  = (LOCK_WAIT_TICKS > SW_MAX) ? LOCK_WAIT_TICKS : SW_MAX;
  localparam int MAX_B  = (UNLOCK_TICKS > FIXED_CYCLES) ? UNLOCK_TICKS : FIXED_CYCLES;
  localparam int MAX_V  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW     = $clog2(MAX_V + 1) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] swTarget;
  logic [CW-1:0] unlockTarget;

  always_ff @(posedge clk) begin
    if (!rstN)             cnt <= '0;
    else if (strobe.clear) cnt <= '0;
    else if (strobe.inc)   cnt <= cnt + 1'b1;
  end

  always_comb begin
    swTarget     = CW'(SW_BASE) << swCode;
    unlockTarget = unlockMode ? CW'(FIXED_CYCLES) : CW'(UNLOCK_TICKS);
  end

  assign hitSwitch = (cnt >= swTarget);
  assign hitWait   = (cnt == CW'(LOCK_WAIT_TICKS));
  assign hitUnlock = (cnt == unlockTarget);

endmodule

// File: rtl/csm_ctrl.sv
module csm_ctrl import csm_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pllLocked,
  input  logic       dataDetected,
  input  logic       xtalTick,
  input  logic       unlockMode,
  input  logic       hitSwitch,
  input  logic       hitWait,
  input  logic       hitUnlock,
  output cntStrobe_t strobe,
  output logic       muteActive,
  output logic       errFlag,
  output logic       srcSel
);

  seqState_t state;
  logic      startLock;
  logic      lostLock;

  assign startLock = (state == ST_IDLE) && pllLocked && dataDetected && xtalTick;
  assign lostLock  = !pllLocked && ((state == ST_LOCKING) || (state == ST_LOCKED));

  always_comb begin
    strobe.clear = startLock || lostLock;
    strobe.inc   = 1'b0;
    if (state == ST_LOCKING)   strobe.inc = xtalTick;
    if (state == ST_UNLOCKING) strobe.inc = unlockMode ? 1'b1 : xtalTick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      muteActive <= 1'b0;
      errFlag    <= 1'b1;
      srcSel     <= 1'b0;
    end else if (lostLock) begin
      state      <= ST_UNLOCKING;
      muteActive <= 1'b1;
      errFlag    <= 1'b1;
      srcSel     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startLock) begin
            state      <= ST_LOCKING;
            muteActive <= 1'b1;
          end
        end
        ST_LOCKING: begin
          if (hitSwitch) srcSel <= 1'b1;
          if (hitWait) begin
            state      <= ST_LOCKED;
            muteActive <= 1'b0;
            errFlag    <= 1'b0;
          end
        end
        ST_UNLOCKING: begin
          if (hitUnlock) begin
            state      <= ST_IDLE;
            muteActive <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/clk_switch_mute.sv
module clk_switch_mute import csm_pkg::*; #(
  parameter int SW_BASE         = 128,
  parameter int LOCK_WAIT_TICKS = 1536,
  parameter int UNLOCK_TICKS    = 16384,
  parameter int FIXED_CYCLES    = 132710
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pllLocked,
  input  logic       dataDetected,
  input  logic       xtalTick,
  input  logic       cfgMutePol,
  input  logic [1:0] cfgSwitchDelay,
  input  logic       cfgUnlockMode,
  output logic       muteOut,
  output logic       errFlag,
  output logic       clkSrcSel
);

  cntStrobe_t strobe;
  logic       hitSwitch;
  logic       hitWait;
  logic       hitUnlock;
  logic       muteActive;

  csm_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .pllLocked    (pllLocked),
    .dataDetected (dataDetected),
    .xtalTick     (xtalTick),
    .unlockMode   (cfgUnlockMode),
    .hitSwitch    (hitSwitch),
    .hitWait      (hitWait),
    .hitUnlock    (hitUnlock),
    .strobe       (strobe),
    .muteActive   (muteActive),
    .errFlag      (errFlag),
    .srcSel       (clkSrcSel)
  );

  csm_count #(
    .SW_BASE         (SW_BASE),
    .LOCK_WAIT_TICKS (LOCK_WAIT_TICKS),
    .UNLOCK_TICKS    (UNLOCK_TICKS),
    .FIXED_CYCLES    (FIXED_CYCLES)
  ) u_count (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .swCode     (cfgSwitchDelay),
    .unlockMode (cfgUnlockMode),
    .hitSwitch  (hitSwitch),
    .hitWait    (hitWait),
    .hitUnlock  (hitUnlock)
  );

  assign muteOut = cfgMutePol ? muteActive : !muteActive;

endmodule

// File: rtl/csm_chk.sv
module csm_chk (
  input logic clk,
  input logic rstN,
  input logic pllLocked,
  input logic xtalTick,
  input logic muteActive,
  input logic errFlag,
  input logic clkSrcSel
);

  // R10
  sel_under_mute_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(clkSrcSel) |-> muteActive);

  // R6
  unlock_react_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pllLocked && !errFlag) |=> (errFlag && muteActive && !clkSrcSel));

  // R5
  err_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errFlag) |-> $fell(muteActive));

  // R3
  mute_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(muteActive) |-> ($past(xtalTick) || !$past(pllLocked)));

  // R4
  pll_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkSrcSel) |-> $past(pllLocked));

endmodule

bind clk_switch_mute csm_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pllLocked  (pllLocked),
  .xtalTick   (xtalTick),
  .muteActive (muteActive),
  .errFlag    (errFlag),
  .clkSrcSel  (clkSrcSel)
);

// File: tb/sim_clk_switch_mute.sv
`timescale 1ns/1ps
module sim_clk_switch_mute;

  localparam int SW_BASE = 2;
  localparam int WAIT_T  = 20;
  localparam int UNL_T   = 6;
  localparam int FIX_C   = 10;

  // vector: {switch code, unlock mode, polarity, expected switch tick}
  localparam int NV = 4;
  localparam int VEC [NV][4] = '{
    '{0, 0, 0, 2},
    '{1, 1, 0, 4},
    '{2, 0, 1, 8},
    '{3, 1, 1, 16}
  };

  logic clk = 0;
  logic rstN = 0;
  logic pllLocked = 0;
  logic dataDetected = 0;
  logic xtalTick = 0;
  logic cfgMutePol = 0;
  logic [1:0] cfgSwitchDelay = 0;
  logic cfgUnlockMode = 0;
  logic muteOut, errFlag, clkSrcSel;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clk_switch_mute #(
    .SW_BASE(SW_BASE), .LOCK_WAIT_TICKS(WAIT_T),
    .UNLOCK_TICKS(UNL_T), .FIXED_CYCLES(FIX_C)
  ) u0 (
    .clk(clk), .rstN(rstN), .pllLocked(pllLocked), .dataDetected(dataDetected),
    .xtalTick(xtalTick), .cfgMutePol(cfgMutePol), .cfgSwitchDelay(cfgSwitchDelay),
    .cfgUnlockMode(cfgUnlockMode), .muteOut(muteOut), .errFlag(errFlag),
    .clkSrcSel(clkSrcSel)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FIAL_GUARD");
    end
  endtask

  // expected pin value for a given mute state
  function automatic logic expMute(logic act);
    return cfgMutePol ? act : !act;
  endfunction

  task automatic chkState(string req, logic mAct, logic err, logic sel);
    nChk++;
    if (muteOut !== expMute(mAct) || errFlag !== err || clkSrcSel !== sel) begin
      nBad++;
      $display("FAIL %s: mute/err/sel = %b%b%b expected %b%b%b", req,
               muteOut, errFlag, clkSrcSel, expMute(mAct), err, sel);
    end
  endtask

  task automatic cyc(logic t);
    xtalTick = t;
    @(posedge clk);
    #1;
    xtalTick = 0;
  endtask

  task automatic doReset();
    rstN = 0;
    cyc(0); cyc(0);
    rstN = 1;
    cyc(0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    doReset();
    // R1 reset state, polarity 0
    chkState("R1", 1'b0, 1'b1, 1'b0);
    check("R2", {31'd0, muteOut}, 32'd1);

    // table walk: lock-in with each switch code, then unlock per mode
    for (int v = 0; v < NV; v++) begin
      cfgSwitchDelay = VEC[v][0][1:0];
      cfgUnlockMode  = VEC[v][1][0];
      cfgMutePol     = VEC[v][2][0];
      pllLocked = 1; dataDetected = 1;
      cyc(1);
      // R3 mute active after the asserting tick; R2 polarity at the pin
      chkState("R3", 1'b1, 1'b1, 1'b0);
      for (int k = 1; k <= WAIT_T; k++) begin
        cyc(1); cyc(0);
        // R4 switch tick, R5 release after WAIT_T ticks
        chkState((k < WAIT_T) ? "R4" : "R5", k < WAIT_T, k < WAIT_T, k >= VEC[v][3]);
      end
      cyc(0);
      chkState("R5", 1'b0, 1'b0, 1'b1);
      pllLocked = 0;
      cyc(0);
      chkState("R6", 1'b1, 1'b1, 1'b0);
      if (cfgUnlockMode == 1'b0) begin
        for (int k = 1; k <= UNL_T; k++) begin
          cyc(1); cyc(0);
          chkState("R7", k < UNL_T, 1'b1, 1'b0);
        end
      end else begin
        for (int n = 1; n <= FIX_C + 1; n++) begin
          cyc(0);
          chkState("R8", n <= FIX_C, 1'b1, 1'b0);
        end
      end
      cyc(0);
      chkState("R11", 1'b0, 1'b1, 1'b0);
    end

    // R3 no tick -> no mute
    cfgMutePol = 0; cfgSwitchDelay = 0; cfgUnlockMode = 0;
    pllLocked = 1; dataDetected = 1;
    repeat (5) cyc(0);
    chkState("R3", 1'b0, 1'b1, 1'b0);
    // R3 data not detected -> tick ignored
    dataDetected = 0;
    cyc(1); cyc(0);
    chkState("R3", 1'b0, 1'b1, 1'b0);

    // R9 abort after the source already moved to PLL
    dataDetected = 1;
    cyc(1);
    for (int k = 1; k <= 3; k++) begin cyc(1); cyc(0); end
    chkState("R9", 1'b1, 1'b1, 1'b1);
    pllLocked = 0;
    cyc(0);
    chkState("R9", 1'b1, 1'b1, 1'b0);
    // R11 lock returns during unlock count: length unchanged
    pllLocked = 1; dataDetected = 0;
    for (int k = 1; k <= UNL_T; k++) begin
      cyc(1); cyc(0);
      chkState("R11", k < UNL_T, 1'b1, 1'b0);
    end
    cyc(0);
    chkState("R11", 1'b0, 1'b1, 1'b0);

    // R1 reset mid-sequence returns to the reset state
    dataDetected = 1;
    cyc(1); cyc(1); cyc(0);
    doReset();
    chkState("R1", 1'b0, 1'b1, 1'b0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule